// File: doc/BRIEF.md
# Pseudo-Random Pattern Receive Sync Monitor

The monitor checks a serial receive bit stream against one of two maximal-length test sequences. In E1 line mode the sequence has period 2^15-1; in T1 line mode it has period 2^20-1. An invert control makes the checker expect the complemented sequence.

A self-synchronising history register predicts each bit from the bits before it. While the monitor is out of sync, it fills that history from the line. Once sync is held, the history free-runs on its own predictions, so a single line error counts once and does not propagate. Errors are tallied over back-to-back 64-bit windows, and the sync decision is taken at each window boundary.

While in sync, a saturating counter accumulates bit errors. A sticky flag records sync transitions, either rising only or any change, and the interrupt line is that flag qualified by a mask.

Top module: `prbs_sync_mon`

## Requirements
- R1: After reset, sync_o is 0, err_cnt_o is 0, flag_o is 0 and irq_o is 0.
- R2: Each bit is predicted from the previous bits in the history. With mode_i=0 the prediction is b[n]=b[n-14]^b[n-15]. With mode_i=1 it is b[n]=b[n-17]^b[n-20]. A bit error is a received bit that differs from its prediction.
- R3: With inv_i=1, each received bit is complemented before it is compared and before it enters the history.
- R4: While sync_o is 0, the history shifts in the received bit. While sync_o is 1, it shifts in the predicted bit.
- R5: Only bits presented with valid_i=1 are checked or counted. Windows are consecutive and non-overlapping runs of 64 valid bits, counted from reset.
- R6: On the clock edge that takes the 64th bit of a window, sync_o becomes 1 if that window held 6 or fewer errors and 0 if it held more. sync_o changes at no other time.
- R7: err_cnt_o (16 bits) increments by one for each bit error received while sync_o is 1 before that bit. It saturates at 0xFFFF (2^CNT_W-1 in general).
- R8: With edge_mode_i=0, flag_o sets in the cycle after sync_o rises. With edge_mode_i=1, it sets in the cycle after any change of sync_o.
- R9: flag_o stays set until a cycle with clr_i=1. If a set event occurs in that same cycle, the flag stays 1.
- R10: irq_o equals flag_o AND mask_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Received bit qualifier |
| data_i | input | 1 | Received bit |
| mode_i | input | 1 | Line mode: 0 E1 (2^15-1), 1 T1 (2^20-1) |
| inv_i | input | 1 | Expect complemented pattern |
| edge_mode_i | input | 1 | 0 rising-only capture, 1 any-change capture |
| mask_i | input | 1 | Interrupt enable |
| clr_i | input | 1 | Sticky flag clear strobe |
| sync_o | output | 1 | Pattern sync status |
| err_cnt_o | output | CNT_W | Saturating error count |
| flag_o | output | 1 | Sticky sync-change flag |
| irq_o | output | 1 | Interrupt |

## Verification
A corrupted history or a wrong tap shows as bit errors. Those errors surface at sync_o no later than the end of the current 64-bit window, and at err_cnt_o on the very next edge when sync is held. A window counter that is off by even one bit moves the sync decision away from the boundary, and this shows up when exactly 6 or 7 errors are injected into one window. A fault in the capture logic shows on flag_o one cycle after a sync transition.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;
  localparam int unsigned HIST_W = 20;
  typedef enum logic { LINE_E1 = 1'b0, LINE_T1 = 1'b1 } line_mode_e;
endpackage

// File: rtl/prbs_ref.sv
module prbs_ref
  import prbs_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  input  logic mode_i,
  input  logic locked_i,
  output logic err_o
);
  logic [HIST_W-1:0] hist_q;
  logic              pred;

  always_comb begin
    if (mode_i == LINE_T1) pred = hist_q[19] ^ hist_q[16];
    else                   pred = hist_q[14] ^ hist_q[13];
  end

  assign err_o = valid_i & (bit_i ^ pred);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (valid_i) hist_q <= {hist_q[HIST_W-2:0], locked_i ? pred : bit_i};
  end

  assert_history_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(valid_i) && !$past(locked_i)) |-> hist_q[0] == $past(bit_i));
  assert_history_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(valid_i)) |-> $stable(hist_q));
endmodule

// File: rtl/win_judge.sv
module win_judge #(
  parameter int unsigned WIN_LEN    = 64,
  parameter int unsigned ERR_THRESH = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic err_i,
  output logic sync_o
);
  localparam int unsigned BC_W    = $clog2(WIN_LEN);
  localparam int unsigned TALLY_W = $clog2(WIN_LEN + 1);

  logic [BC_W-1:0]    bit_cnt_q;
  logic [TALLY_W-1:0] tally_q, total;
  logic               sync_q, win_end;

  assign win_end = valid_i && (bit_cnt_q == BC_W'(WIN_LEN - 1));
  assign total   = tally_q + TALLY_W'(err_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      tally_q   <= '0;
      sync_q    <= 1'b0;
    end else if (valid_i) begin
      if (win_end) begin
        bit_cnt_q <= '0;
        tally_q   <= '0;
        sync_q    <= (total <= TALLY_W'(ERR_THRESH));
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        tally_q   <= total;
      end
    end
  end

  assign sync_o = sync_q;

  assert_tally_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tally_q < TALLY_W'(WIN_LEN));
  assert_sync_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sync_q) && $past(rst_ni)) |-> $past(win_end));
  assert_rise_threshold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sync_q) && $past(rst_ni)) |-> $past(total) <= TALLY_W'(ERR_THRESH));
endmodule

// File: rtl/err_accum.sv
module err_accum #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_cnt_monotonic_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q >= $past(cnt_q));
  assert_cnt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(inc_i)) |-> $stable(cnt_q));
endmodule

// File: rtl/sticky_irq.sv
module sticky_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic flag_o
);
  logic prev_q, flag_q, ev;

  assign ev = edge_mode_i ? (sync_i ^ prev_q) : (sync_i & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      flag_q <= ev | (flag_q & ~clr_i);
    end
  end

  assign flag_o = flag_q;

  assert_set_priority_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(ev)) |-> flag_q);
  assert_set_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_q) && $past(rst_ni)) |-> $past(ev));
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(clr_i) && !$past(ev)) |-> !flag_q);
endmodule

// File: rtl/prbs_sync_mon.sv
module prbs_sync_mon #(
  parameter int unsigned WIN_LEN    = 64,
  parameter int unsigned ERR_THRESH = 6,
  parameter int unsigned CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             data_i,
  input  logic             mode_i,
  input  logic             inv_i,
  input  logic             edge_mode_i,
  input  logic             mask_i,
  input  logic             clr_i,
  output logic             sync_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic bit_eff, bit_err, sync;

  assign bit_eff = data_i ^ inv_i;

  prbs_ref u_ref (
    .clk_i, .rst_ni, .valid_i, .bit_i(bit_eff), .mode_i,
    .locked_i(sync), .err_o(bit_err)
  );

  win_judge #(.WIN_LEN(WIN_LEN), .ERR_THRESH(ERR_THRESH)) u_judge (
    .clk_i, .rst_ni, .valid_i, .err_i(bit_err), .sync_o(sync)
  );

  err_accum #(.CNT_W(CNT_W)) u_accum (
    .clk_i, .rst_ni, .inc_i(bit_err & sync), .cnt_o(err_cnt_o)
  );

  sticky_irq u_sticky (
    .clk_i, .rst_ni, .sync_i(sync), .edge_mode_i, .clr_i, .flag_o
  );

  assign sync_o = sync;
  assign irq_o  = flag_o & mask_i;

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_o |-> !irq_o);
endmodule

// File: tb/prbs_sync_mon_bench.sv
`timescale 1ns/1ps
module prbs_sync_mon_bench;
  localparam int NARROW_W = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 0, data_i = 0, mode_i = 0, inv_i = 0, edge_mode_i = 0, mask_i = 0, clr_i = 0;
  logic sync_o, flag_o, irq_o;
  logic [15:0] err_cnt_o;
  logic n_sync, n_flag, n_irq;
  logic [NARROW_W-1:0] n_cnt;

  always #4 clk_i = ~clk_i;

  prbs_sync_mon u_prbs_sync_mon (
    .clk_i, .rst_ni, .valid_i, .data_i, .mode_i, .inv_i, .edge_mode_i, .mask_i, .clr_i,
    .sync_o, .err_cnt_o, .flag_o, .irq_o
  );

  prbs_sync_mon #(.CNT_W(NARROW_W)) u_prbs_sync_mon_narrow (
    .clk_i, .rst_ni, .valid_i, .data_i, .mode_i, .inv_i, .edge_mode_i, .mask_i, .clr_i,
    .sync_o(n_sync), .err_cnt_o(n_cnt), .flag_o(n_flag), .irq_o(n_irq)
  );

  int n_cmp = 0, n_bad = 0;
  logic [19:0] m_h, g_h;
  logic m_sync, m_prev, m_flag, line_inv;
  int m_bitcnt, m_tally, m_cnt, m_cnt_n;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic predict(input logic [19:0] h, input logic md);
    return md ? (h[19] ^ h[16]) : (h[14] ^ h[13]);
  endfunction

  function automatic int sat_inc(input int v, input int w);
    return (v < (1 << w) - 1) ? v + 1 : v;
  endfunction

  task automatic model_reset();
    m_h = '0; m_sync = 0; m_prev = 0; m_flag = 0;
    m_bitcnt = 0; m_tally = 0; m_cnt = 0; m_cnt_n = 0;
  endtask

  task automatic reseed();
    g_h = 20'($urandom) | 20'h1;
  endtask

  task automatic step(input logic v, input logic flip);
    logic g, d, pred, e, nf, ns;
    g = predict(g_h, mode_i);
    if (v) g_h = {g_h[18:0], g};
    valid_i = v;
    data_i  = v ? (g ^ line_inv ^ flip) : 1'($urandom);
    nf = (edge_mode_i ? (m_sync != m_prev) : (m_sync && !m_prev)) || (m_flag && !clr_i);
    m_prev = m_sync;
    if (v) begin
      d = data_i ^ inv_i;
      pred = predict(m_h, mode_i);
      e = (d != pred);
      if (m_sync && e) begin
        m_cnt = sat_inc(m_cnt, 16);
        m_cnt_n = sat_inc(m_cnt_n, NARROW_W);
      end
      ns = m_sync;
      if (m_bitcnt == 63) begin
        ns = (m_tally + int'(e)) <= 6;
        m_tally = 0;
      end else m_tally += int'(e);
      m_bitcnt = (m_bitcnt + 1) % 64;
      m_h = {m_h[18:0], m_sync ? pred : d};
      m_sync = ns;
    end
    m_flag = nf;
    @(posedge clk_i);
    #2;
    chk("R6 sync", int'(sync_o), int'(m_sync));
    chk("R7 count", int'(err_cnt_o), m_cnt);
    chk("R7 narrow count", int'(n_cnt), m_cnt_n);
    chk("R8 flag", int'(flag_o), int'(m_flag));
    chk("R10 irq", int'(irq_o), int'(m_flag && mask_i));
  endtask

  // one window, n_err flips at positions 3+9k, optional invalid gaps (R5)
  task automatic run_window(input int n_err, input bit gaps);
    int done = 0;
    while (done < 64) begin
      if (gaps && ($urandom % 5 == 0)) step(1'b0, 1'b0);
      else begin
        int p = m_bitcnt;
        step(1'b1, (p >= 3) && ((p - 3) % 9 == 0) && ((p - 3) / 9 < n_err));
        done++;
      end
    end
  endtask

  task automatic run_random(input int nbits, input int rate);
    for (int i = 0; i < nbits; i++) step(1'b1, ($urandom % rate) == 0);
  endtask

  initial begin
    void'($urandom(32'd20250611));
    model_reset(); line_inv = 0; reseed();
    #20;
    chk("R1 sync", int'(sync_o), 0);
    chk("R1 count", int'(err_cnt_o), 0);
    chk("R1 flag", int'(flag_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    @(negedge clk_i); rst_ni = 1; #1;

    // R2 E1 acquisition, rising-only capture, mask on
    mask_i = 1;
    repeat (3) run_window(0, 1'b1);
    chk("R2 E1 lock", int'(sync_o), 1);
    chk("R8 rise flag", int'(flag_o), 1);
    // R6 boundary: 6 errors keep sync, 7 drop it
    repeat (2) run_window(6, 1'b1);
    chk("R6 six keeps", int'(sync_o), 1);
    chk("R7 count 12", int'(err_cnt_o), 12);
    clr_i = 1; step(1'b0, 1'b0); clr_i = 0;
    chk("R9 cleared", int'(flag_o), 0);
    run_window(7, 1'b0);
    chk("R6 seven drops", int'(sync_o), 0);
    step(1'b0, 1'b0);
    chk("R8 fall ignored", int'(flag_o), 0);
    // R8 any-change capture with clear held across the event (R9)
    edge_mode_i = 1;
    clr_i = 1;
    run_window(0, 1'b0);
    step(1'b0, 1'b0);
    chk("R9 set wins", int'(flag_o), 1);
    step(1'b0, 1'b0);
    clr_i = 0;
    chk("R9 cleared later", int'(flag_o), 0);
    mask_i = 0;
    run_window(7, 1'b0);
    step(1'b0, 1'b0);
    chk("R8 fall captured", int'(flag_o), 1);
    chk("R10 masked", int'(irq_o), 0);
    mask_i = 1;
    // R3: inverted line, invert off -> every bit wrong
    run_window(0, 1'b0);
    line_inv = 1;
    repeat (2) run_window(0, 1'b0);
    chk("R3 mismatch unsynced", int'(sync_o), 0);
    // R2/R3/R4 T1 mode with matching inversion and random errors
    mode_i = 1; inv_i = 1; reseed();
    repeat (3) run_window(0, 1'b1);
    chk("R2 T1 lock", int'(sync_o), 1);
    run_random(640, 40);
    run_random(256, 3);
    run_random(256, 200);
    // R7 narrow saturation at 63 while sync held
    mode_i = 0; inv_i = 0; line_inv = 0; reseed();
    repeat (3) run_window(0, 1'b0);
    repeat (12) run_window(6, 1'b1);
    chk("R7 narrow saturates", int'(n_cnt), (1 << NARROW_W) - 1);
    run_random(400, 25);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule